// File: doc/BRIEF.md
# USB PHY Power Sequencer

This block steps an on-chip USB 2.0 PHY and its PLL through power-up and power-down. A single-cycle power-on request releases the PHY from reset and from both power-down controls and turns the PLL on, all in one register update. The sequencer then waits for the PHY to report a good clock before it raises `ready`. A programmable cycle bound limits that wait. If the bound expires, the sequencer flags a timeout and puts the PHY back into its reset condition.

A power-off request sets the PHY power-down and OTG power-down controls. It is refused when a second, USB 1.1 controller takes its reference clock from this PHY. That case is recognised by a clock-mux select of 0 together with a USB 1.1 suspend-control level of 1. A refused request leaves every control as it was, keeps `ready` high and produces a one-cycle `refused` pulse. Requests that arrive in a state where they do not apply, including during the clock-good wait, have no effect.

Top module: `usb_phy_pwr_seq`

## Requirements
- R1: While reset is held and after it is released, the outputs stay at their initial values until a request is accepted. The initial values are phy_reset=1, phy_pwrdn=1, otg_pwrdn=1, pll_on=0, ready=0, refused=0 and timeout=0.
- R2: A power-on request accepted in the powered-down state changes the outputs in the next cycle. phy_reset, phy_pwrdn and otg_pwrdn go to 0, pll_on goes to 1, ready stays 0 and timeout goes to 0.
- R3: During the wait, ready rises in the cycle after the first waiting cycle in which clk_good is 1, and never earlier.
- R4: If clk_good stays 0 for max(timeout_limit,1) waiting cycles, the next cycle shows timeout=1 with phy_reset=1, phy_pwrdn=1, otg_pwrdn=1 and pll_on=0. The flag holds until the next accepted power-on request.
- R5: A power-off request while ready, with the interlock not active, sets phy_pwrdn and otg_pwrdn to 1 and clears ready in the next cycle. phy_reset and pll_on keep their values.
- R6: A power-off request while ready, with usb11_clk_sel=0 and usb11_suspend_ctl=1, changes no control. In the next cycle it gives exactly one cycle of refused=1, and ready stays 1.
- R7: A power-on request while waiting or ready has no effect. A power-off request while powered down or waiting also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on_req | input | 1 | Power-on request |
| pwr_off_req | input | 1 | Power-off request |
| clk_good | input | 1 | PHY clock-good indication |
| usb11_clk_sel | input | 1 | USB 1.1 reference clock select; 0 means sourced from this PHY |
| usb11_suspend_ctl | input | 1 | USB 1.1 suspend-control level |
| timeout_limit | input | CNT_W | Clock-good wait bound in cycles (0 acts as 1) |
| phy_reset | output | 1 | PHY reset control |
| phy_pwrdn | output | 1 | PHY power-down control |
| otg_pwrdn | output | 1 | OTG power-down control |
| pll_on | output | 1 | PHY PLL enable |
| ready | output | 1 | PHY powered with clock good |
| refused | output | 1 | One-cycle pulse for a refused power-off |
| timeout | output | 1 | Clock-good wait expired |

## Verification
The power-up path is tried three ways: with clk_good arriving after a few cycles, with clk_good never arriving under a limit of 5, and with a limit of 0. These separate a correct ready handshake from an off-by-one in the wait bound and from a missing zero-limit guard. Power-off is driven under three interlock input combinations. Only one of them (select 0, suspend 1) may block, so a swapped or inverted term in the interlock shows up. Requests are also issued in every state where they must be ignored, both on their own and alongside a pending clk_good.

// File: rtl/usb_pwr_seq_pkg.sv
package usb_pwr_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_ON   = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       phy_reset;
        logic       phy_pwrdn;
        logic       otg_pwrdn;
        logic       pll_on;
        logic       ready;
        logic       refused;
        logic       timeout;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        state:     SEQ_OFF,
        phy_reset: 1'b1,
        phy_pwrdn: 1'b1,
        otg_pwrdn: 1'b1,
        pll_on:    1'b0,
        ready:     1'b0,
        refused:   1'b0,
        timeout:   1'b0
    };

endpackage

// File: rtl/clk_good_timer.sv
module clk_good_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [EXT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = EXT_W'(cnt_q) + EXT_W'(1);
        expired = run && (cnt_inc >= EXT_W'(limit));
        cnt_d   = cnt_q;
        if (start) begin
            cnt_d = '0;
        end else if (run && !expired) begin
            cnt_d = cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/clk_share_guard.sv
module clk_share_guard (
    input  logic mux_sel,
    input  logic dep_suspend,
    output logic hold_power
);
    always_comb begin
        hold_power = !mux_sel && dep_suspend;
    end
endmodule

// File: rtl/usb_phy_pwr_seq.sv
module usb_phy_pwr_seq
    import usb_pwr_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on_req,
    input  logic             pwr_off_req,
    input  logic             clk_good,
    input  logic             usb11_clk_sel,
    input  logic             usb11_suspend_ctl,
    input  logic [CNT_W-1:0] timeout_limit,
    output logic             phy_reset,
    output logic             phy_pwrdn,
    output logic             otg_pwrdn,
    output logic             pll_on,
    output logic             ready,
    output logic             refused,
    output logic             timeout
);
    seq_regs_t r_d, r_q;
    logic      tmr_start, tmr_run, tmr_expired;
    logic      hold_power;
    logic      st_off, st_wait, st_on;

    clk_good_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .run     (tmr_run),
        .limit   (timeout_limit),
        .expired (tmr_expired)
    );

    clk_share_guard i_guard (
        .mux_sel     (usb11_clk_sel),
        .dep_suspend (usb11_suspend_ctl),
        .hold_power  (hold_power)
    );

    always_comb begin
        st_off  = (r_q.state == SEQ_OFF);
        st_wait = (r_q.state == SEQ_WAIT);
        st_on   = (r_q.state == SEQ_ON);
    end

    always_comb begin
        r_d         = r_q;
        r_d.refused = 1'b0;
        tmr_start   = 1'b0;
        tmr_run     = st_wait && !clk_good;
        unique case (r_q.state)
            SEQ_OFF: begin
                if (pwr_on_req) begin
                    r_d.phy_reset = 1'b0;
                    r_d.phy_pwrdn = 1'b0;
                    r_d.otg_pwrdn = 1'b0;
                    r_d.pll_on    = 1'b1;
                    r_d.timeout   = 1'b0;
                    r_d.state     = SEQ_WAIT;
                    tmr_start     = 1'b1;
                end
            end
            SEQ_WAIT: begin
                if (clk_good) begin
                    r_d.ready = 1'b1;
                    r_d.state = SEQ_ON;
                end else if (tmr_expired) begin
                    r_d.timeout   = 1'b1;
                    r_d.phy_reset = 1'b1;
                    r_d.phy_pwrdn = 1'b1;
                    r_d.otg_pwrdn = 1'b1;
                    r_d.pll_on    = 1'b0;
                    r_d.state     = SEQ_OFF;
                end
            end
            SEQ_ON: begin
                if (pwr_off_req) begin
                    if (hold_power) begin
                        r_d.refused = 1'b1;
                    end else begin
                        r_d.phy_pwrdn = 1'b1;
                        r_d.otg_pwrdn = 1'b1;
                        r_d.ready     = 1'b0;
                        r_d.state     = SEQ_OFF;
                    end
                end
            end
            default: r_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SEQ_RESET;
        else        r_q <= r_d;
    end

    assign phy_reset = r_q.phy_reset;
    assign phy_pwrdn = r_q.phy_pwrdn;
    assign otg_pwrdn = r_q.otg_pwrdn;
    assign pll_on    = r_q.pll_on;
    assign ready     = r_q.ready;
    assign refused   = r_q.refused;
    assign timeout   = r_q.timeout;
endmodule

// File: rtl/usb_phy_pwr_seq_chk.sv
module usb_phy_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_on_req,
    input logic pwr_off_req,
    input logic clk_good,
    input logic usb11_clk_sel,
    input logic usb11_suspend_ctl,
    input logic phy_reset,
    input logic phy_pwrdn,
    input logic otg_pwrdn,
    input logic pll_on,
    input logic ready,
    input logic refused,
    input logic timeout,
    input logic st_off,
    input logic st_on
);
    AST_PWRUP_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_off && pwr_on_req) |=> (!phy_reset && !phy_pwrdn && !otg_pwrdn && pll_on && !ready)); // R2

    AST_READY_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(clk_good)); // R3

    AST_TIMEOUT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (phy_reset && phy_pwrdn && otg_pwrdn && !pll_on && !ready)); // R4

    AST_PWRDN_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_on && pwr_off_req && (usb11_clk_sel || !usb11_suspend_ctl))
        |=> (phy_pwrdn && otg_pwrdn && !ready && $stable(pll_on))); // R5

    AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_on && pwr_off_req && !usb11_clk_sel && usb11_suspend_ctl)
        |=> (refused && ready && !phy_pwrdn && !otg_pwrdn && pll_on)); // R6

    AST_IGNORE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (st_on && pwr_on_req && !pwr_off_req) |=> (ready && !refused && $stable(phy_pwrdn))); // R7
endmodule

bind usb_phy_pwr_seq usb_phy_pwr_seq_chk i_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .pwr_on_req        (pwr_on_req),
    .pwr_off_req       (pwr_off_req),
    .clk_good          (clk_good),
    .usb11_clk_sel     (usb11_clk_sel),
    .usb11_suspend_ctl (usb11_suspend_ctl),
    .phy_reset         (phy_reset),
    .phy_pwrdn         (phy_pwrdn),
    .otg_pwrdn         (otg_pwrdn),
    .pll_on            (pll_on),
    .ready             (ready),
    .refused           (refused),
    .timeout           (timeout),
    .st_off            (st_off),
    .st_on             (st_on)
);

// File: tb/test_usb_phy_pwr_seq.sv
module test_usb_phy_pwr_seq;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_on_req = 1'b0;
    logic             pwr_off_req = 1'b0;
    logic             clk_good = 1'b0;
    logic             usb11_clk_sel = 1'b1;
    logic             usb11_suspend_ctl = 1'b0;
    logic [CNT_W-1:0] timeout_limit = CNT_W'(5);
    logic phy_reset, phy_pwrdn, otg_pwrdn, pll_on, ready, refused, timeout;

    usb_phy_pwr_seq #(.CNT_W(CNT_W)) i_usb_phy_pwr_seq (
        .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
        .clk_good(clk_good), .usb11_clk_sel(usb11_clk_sel),
        .usb11_suspend_ctl(usb11_suspend_ctl), .timeout_limit(timeout_limit),
        .phy_reset(phy_reset), .phy_pwrdn(phy_pwrdn), .otg_pwrdn(otg_pwrdn),
        .pll_on(pll_on), .ready(ready), .refused(refused), .timeout(timeout)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // Behavioural reference: 0 = down, 1 = waiting, 2 = up
    int m_state, m_wait;
    bit m_rst, m_ppd, m_opd, m_pll, m_rdy, m_ref, m_to;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_wait = 0;
            m_rst = 1; m_ppd = 1; m_opd = 1; m_pll = 0; m_rdy = 0; m_ref = 0; m_to = 0;
        end else begin
            m_ref = 0;
            if (m_state == 0) begin
                if (pwr_on_req) begin
                    m_rst = 0; m_ppd = 0; m_opd = 0; m_pll = 1; m_to = 0;
                    m_wait = 0; m_state = 1;
                end
            end else if (m_state == 1) begin
                if (clk_good) begin
                    m_rdy = 1; m_state = 2;
                end else begin
                    m_wait++;
                    if (m_wait >= ((int'(timeout_limit) == 0) ? 1 : int'(timeout_limit))) begin
                        m_to = 1; m_rst = 1; m_ppd = 1; m_opd = 1; m_pll = 0; m_state = 0;
                    end
                end
            end else if (pwr_off_req) begin
                if (!usb11_clk_sel && usb11_suspend_ctl) m_ref = 1;
                else begin
                    m_ppd = 1; m_opd = 1; m_rdy = 0; m_state = 0;
                end
            end
        end
    end

    task automatic chk(string name, logic act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, name, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("phy_reset", phy_reset, m_rst);
            chk("phy_pwrdn", phy_pwrdn, m_ppd);
            chk("otg_pwrdn", otg_pwrdn, m_opd);
            chk("pll_on", pll_on, m_pll);
            chk("ready", ready, m_rdy);
            chk("refused", refused, m_ref);
            chk("timeout", timeout, m_to);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most 20000", cycles);
            finish_run();
        end
    end

    initial begin
        tag = "R1";
        step(3);
        rst_n = 1'b1;
        step(3);

        tag = "R7";
        pwr_off_req = 1'b1; step(2); pwr_off_req = 1'b0;

        tag = "R2";
        pwr_on_req = 1'b1; step(1); pwr_on_req = 1'b0;
        tag = "R7";
        pwr_on_req = 1'b1; pwr_off_req = 1'b1; step(2);
        pwr_on_req = 1'b0; pwr_off_req = 1'b0;
        tag = "R3";
        clk_good = 1'b1; step(1); clk_good = 1'b0; step(2);

        tag = "R7";
        pwr_on_req = 1'b1; step(2); pwr_on_req = 1'b0;

        tag = "R6";
        usb11_clk_sel = 1'b0; usb11_suspend_ctl = 1'b1;
        pwr_off_req = 1'b1; step(1); pwr_off_req = 1'b0; step(2);
        pwr_off_req = 1'b1; step(3); pwr_off_req = 1'b0; step(1);

        tag = "R5";
        usb11_clk_sel = 1'b1; usb11_suspend_ctl = 1'b1;
        pwr_off_req = 1'b1; step(1); pwr_off_req = 1'b0; step(2);

        tag = "R4";
        timeout_limit = CNT_W'(5);
        pwr_on_req = 1'b1; step(1); pwr_on_req = 1'b0; step(8);
        timeout_limit = CNT_W'(0);
        pwr_on_req = 1'b1; step(1); pwr_on_req = 1'b0; step(3);
        timeout_limit = CNT_W'(5);
        pwr_on_req = 1'b1; step(1); pwr_on_req = 1'b0; step(4);
        tag = "R3";
        clk_good = 1'b1; step(2); clk_good = 1'b0;

        tag = "R5";
        usb11_clk_sel = 1'b0; usb11_suspend_ctl = 1'b0;
        pwr_off_req = 1'b1; step(1); pwr_off_req = 1'b0; step(2);

        tag = "R2";
        usb11_clk_sel = 1'b0; usb11_suspend_ctl = 1'b1;
        pwr_on_req = 1'b1; clk_good = 1'b1; step(1); pwr_on_req = 1'b0; step(2);
        clk_good = 1'b0;
        tag = "R6";
        pwr_off_req = 1'b1; step(1); pwr_off_req = 1'b0; step(2);

        tag = "R1";
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(2);

        @(negedge clk);
        #1;
        finish_run();
    end
endmodule